// File: doc/BRIEF.md
# Flash Converter Thermometer Encoder

This block takes the latched comparator word of a flash converter and turns it into a registered binary code and an overflow flag. The array has 512 comparators. A comparator whose threshold lies below the analog input reads 1, and one whose threshold lies above it reads 0. The word is therefore a run of ones starting at bit 0. The top comparator, at the most positive threshold, is not counted in the code. It only reports overflow.

The work is split across the edges of the convert clock. The rising edge latches the comparator word. The following falling edge encodes it. The next rising edge loads the output register. A sample therefore reaches the outputs one convert period after it was taken.

The native code counts downward, so the most positive input gives code 0. The code can also be presented bitwise inverted, or in offset two's complement form. The format is chosen per sample and latched together with the comparator word. The encoder looks for the highest 1-to-0 transition in the word, and it only accepts a transition that has a 1 beneath it. A lone stray comparator above the run, or a lone hole inside it, therefore does not move the result.

Top module: `flash_thermo_encoder`

## Requirements
- R1: A synchronous reset, sampled on the rising edge, clears the latched word, the encode stage and the output register. After a reset edge `data_o` is 0 and `ovf_o` is 0.
- R2: The comparator word and `fmt_i` are captured on a rising edge. The result for that sample appears after the next rising edge and not earlier, so back-to-back samples come out one per cycle in order.
- R3: For a clean run of k ones in bits 0..510 with bit 511 clear, the native code is 511 - k. All zeros gives 511 (111111111), bits 0..510 all set gives 0, 255 ones gives 256 (100000000) and 256 ones gives 255 (011111111).
- R4: The code is taken from the highest index i in 0..510 with bit i = 1, bit i+1 = 0 and bit i-1 = 1, where bit -1 counts as 1; the code is 510 - i, or 511 when no such i exists. A single stray 1 above the run, or a single 0 inside it, leaves the code unchanged.
- R5: `ovf_o` equals bit 511 of the captured word, with the same latency as the code.
- R6: When bit 511 is set, the native code is 0 whatever the other bits hold.
- R7: `fmt_i` = 00 gives the native code, 01 gives its bitwise inverse, 10 gives the native code with only its MSB inverted (offset two's complement), and 11 behaves as 00.
- R8: `data_o` and `ovf_o` change only on a rising edge and hold their value across the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Convert clock; rising edge latches and loads, falling edge encodes |
| rst_i | input | 1 | Synchronous active-high reset |
| therm_i | input | 512 | Comparator word, bit 511 is the most positive threshold |
| fmt_i | input | 2 | Output format select, latched with the word |
| data_o | output | 9 | Registered, formatted code |
| ovf_o | output | 1 | Registered overflow flag |

## Verification
The bench streams samples back to back. A design that skipped the falling-edge stage, or added a register of its own, would put every code one slot off against the queue.

The range ends and the midpoint crossing are driven directly. An off-by-one in the subtraction from the top index shows up at exactly these codes.

Bubbled words, with a hole in the run or a lone stray 1 above it, would give a different code if the encoder only counted ones or took the raw top edge. Overflow words carrying junk below them catch a design that forgets to saturate. Each format is paired with codes whose MSB differs, so inverting the wrong bits shows.

// File: rtl/flash_enc_pkg.sv
package flash_enc_pkg;

   typedef enum logic [1:0] {
      FMT_NATIVE = 2'b00,
      FMT_INVERT = 2'b01,
      FMT_OFFSET = 2'b10,
      FMT_SPARE  = 2'b11
   } out_fmt_e;

endpackage

// File: rtl/therm_window.sv
module therm_window #(
   parameter int N_CMP        = 512,
   parameter bit BUBBLE_GUARD = 1'b1
) (
   input  logic [N_CMP-1:0] vec_i,
   output logic [N_CMP-2:0] hit_o
);

   for (genvar i = 0; i < N_CMP - 1; i++) begin : g_pos
      if (!BUBBLE_GUARD) begin : g_plain
         assign hit_o[i] = vec_i[i] & ~vec_i[i+1];
      end else if (i == 0) begin : g_floor
         // bit below position 0 is taken as set
         assign hit_o[i] = vec_i[i] & ~vec_i[i+1];
      end else begin : g_guard
         assign hit_o[i] = vec_i[i] & ~vec_i[i+1] & vec_i[i-1];
      end
   end

endmodule

// File: rtl/edge_prio.sv
module edge_prio #(
   parameter int N_IN  = 511,
   parameter int IDX_W = 9
) (
   input  logic [N_IN-1:0]  hit_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             found_o
);

   always_comb begin
      idx_o   = '0;
      found_o = 1'b0;
      for (int i = 0; i < N_IN; i++) begin
         if (hit_i[i]) begin
            idx_o   = IDX_W'(i);
            found_o = 1'b1;
         end
      end
   end

endmodule

// File: rtl/code_format.sv
module code_format
   import flash_enc_pkg::*;
#(
   parameter int W = 9
) (
   input  logic [W-1:0] code_i,
   input  out_fmt_e     fmt_i,
   output logic [W-1:0] code_o
);

   always_comb begin
      unique case (fmt_i)
         FMT_INVERT: code_o = ~code_i;
         FMT_OFFSET: code_o = {~code_i[W-1], code_i[W-2:0]};
         default:    code_o = code_i;
      endcase
   end

endmodule

// File: rtl/flash_thermo_encoder.sv
module flash_thermo_encoder
   import flash_enc_pkg::*;
#(
   parameter int CODE_W       = 9,
   parameter bit BUBBLE_GUARD = 1'b1,
   localparam int NCMP        = 1 << CODE_W
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [NCMP-1:0]   therm_i,
   input  logic [1:0]        fmt_i,
   output logic [CODE_W-1:0] data_o,
   output logic              ovf_o
);

   localparam int TOP_IDX = NCMP - 2;
   localparam int OVF_BIT = NCMP - 1;

   if (CODE_W < 2 || CODE_W > 12) begin : g_bad_width
      $error("flash_thermo_encoder: CODE_W out of range 2..12");
   end

   // stage 1: latch on rising edge
   logic [NCMP-1:0] cap_q;
   out_fmt_e        fmt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cap_q <= '0;
         fmt_q <= FMT_NATIVE;
      end else begin
         cap_q <= therm_i;
         fmt_q <= out_fmt_e'(fmt_i);
      end
   end

   // encode logic
   logic [NCMP-2:0]   hits;
   logic [CODE_W-1:0] top_idx;
   logic              top_found;
   logic [CODE_W-1:0] code_raw;
   logic [CODE_W-1:0] code_sat;

   therm_window #(.N_CMP(NCMP), .BUBBLE_GUARD(BUBBLE_GUARD)) i_window (
      .vec_i (cap_q),
      .hit_o (hits)
   );

   edge_prio #(.N_IN(NCMP-1), .IDX_W(CODE_W)) i_prio (
      .hit_i   (hits),
      .idx_o   (top_idx),
      .found_o (top_found)
   );

   assign code_raw = top_found ? (CODE_W'(TOP_IDX) - top_idx) : '1;
   assign code_sat = cap_q[OVF_BIT] ? '0 : code_raw;

   // stage 2: encode on falling edge
   logic [CODE_W-1:0] enc_code_q;
   logic              enc_ovf_q;

   always_ff @(negedge clk_i) begin
      if (rst_i) begin
         enc_code_q <= '0;
         enc_ovf_q  <= 1'b0;
      end else begin
         enc_code_q <= code_sat;
         enc_ovf_q  <= cap_q[OVF_BIT];
      end
   end

   // stage 3: output register on rising edge
   logic [CODE_W-1:0] code_fmt;

   code_format #(.W(CODE_W)) i_fmt (
      .code_i (enc_code_q),
      .fmt_i  (fmt_q),
      .code_o (code_fmt)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         data_o <= '0;
         ovf_o  <= 1'b0;
      end else begin
         data_o <= code_fmt;
         ovf_o  <= enc_ovf_q;
      end
   end

   // clean run in the latched word must encode to top minus popcount
   a_r3_clean_count: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(rst_i) && !cap_q[OVF_BIT] &&
       ((cap_q[NCMP-2:0] & (cap_q[NCMP-2:0] + 1'b1)) == '0))
      |-> (enc_code_q == CODE_W'(NCMP - 1 - $countones(cap_q[NCMP-2:0]))));

   // encode stage overflow follows the latched top comparator
   a_r5_ovf_capture: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> (enc_ovf_q == cap_q[OVF_BIT]));

   // overflow with native format gives code 0 at the output
   a_r6_sat_native: assert property (@(posedge clk_i) disable iff (rst_i)
      (enc_ovf_q && fmt_q == FMT_NATIVE) |=> (ovf_o && data_o == '0));

   // offset format flips the MSB only
   a_r7_offset_msb: assert property (@(posedge clk_i) disable iff (rst_i)
      (fmt_q == FMT_OFFSET) |=>
      (data_o == {~$past(enc_code_q[CODE_W-1]), $past(enc_code_q[CODE_W-2:0])}));

   // reset edge clears the outputs
   a_r1_reset_clear: assert property (@(posedge clk_i)
      rst_i |=> (data_o == '0 && !ovf_o));

endmodule

// File: tb/test_flash_thermo_encoder.sv
module test_flash_thermo_encoder;

   localparam int CW = 9;
   localparam int NC = 512;

   logic          clk_i = 1'b0;
   logic          rst_i;
   logic [NC-1:0] therm_i;
   logic [1:0]    fmt_i;
   logic [CW-1:0] data_o;
   logic          ovf_o;

   flash_thermo_encoder #(.CODE_W(CW)) i_flash_thermo_encoder (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .therm_i (therm_i),
      .fmt_i   (fmt_i),
      .data_o  (data_o),
      .ovf_o   (ovf_o)
   );

   always #10 clk_i = ~clk_i;   // 50 MHz

   typedef struct {
      logic [CW-1:0] d;
      logic          o;
      int            due;
      string         tag;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   always @(posedge clk_i) cyc <= cyc + 1;

   function automatic logic [NC-1:0] therm(int n);
      logic [NC-1:0] v = '0;
      for (int i = 0; i < NC; i++) if (i < n) v[i] = 1'b1;
      return v;
   endfunction

   // native code from the transition rule of R4 and saturation of R6
   function automatic logic [CW-1:0] model_code(logic [NC-1:0] v);
      if (v[NC-1]) return '0;
      for (int i = NC - 2; i >= 0; i--)
         if (v[i] && !v[i+1] && (i == 0 || v[i-1])) return CW'(NC - 2 - i);
      return '1;
   endfunction

   function automatic logic [CW-1:0] model_fmt(logic [CW-1:0] c, logic [1:0] f);
      case (f)
         2'b01:   return ~c;
         2'b10:   return {~c[CW-1], c[CW-2:0]};
         default: return c;
      endcase
   endfunction

   task automatic check(string tag, logic [CW-1:0] d_act, logic [CW-1:0] d_exp,
                        logic o_act, logic o_exp);
      n_chk++;
      if (d_act !== d_exp || o_act !== o_exp) begin
         n_bad++;
         $display("FAIL %s: data=%b ovf=%b expected data=%b ovf=%b",
                  tag, d_act, o_act, d_exp, o_exp);
      end
   endtask

   // driver: set inputs before the capture edge and queue the expected item
   task automatic apply(logic [NC-1:0] v, logic [1:0] f, string tag);
      exp_t e;
      @(negedge clk_i);
      #5;
      therm_i = v;
      fmt_i   = f;
      e.d   = model_fmt(model_code(v), f);
      e.o   = v[NC-1];
      e.due = cyc + 2;
      e.tag = tag;
      q.push_back(e);
   endtask

   task automatic drain();
      while (q.size() != 0) @(posedge clk_i);
      @(posedge clk_i);
   endtask

   // monitor: compare on due cycles, and check hold across the falling edge
   initial begin
      logic [CW-1:0] last_d;
      logic          last_o;
      forever begin
         @(posedge clk_i);
         #2;
         if (q.size() != 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, data_o, e.d, ovf_o, e.o);
         end
         last_d = data_o;
         last_o = ovf_o;
         @(negedge clk_i);
         #2;
         if (!done && rst_i == 1'b0) check("R8 hold", data_o, last_d, ovf_o, last_o);
      end
   end

   initial begin
      #(20 * 100000);
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [NC-1:0] v;
      rst_i   = 1'b1;
      therm_i = '0;
      fmt_i   = 2'b00;
      repeat (4) @(posedge clk_i);
      #2;
      check("R1 reset state", data_o, '0, ovf_o, 1'b0);
      @(negedge clk_i);
      #5;
      rst_i = 1'b0;

      // R3 range ends and midpoint crossing; R2 latency via back-to-back stream
      apply(therm(0),   2'b00, "R3 all zero");
      apply(therm(511), 2'b00, "R3 full run");
      apply(therm(255), 2'b00, "R3 mid 256");
      apply(therm(256), 2'b00, "R3 mid 255");
      apply(therm(1),   2'b00, "R2 single");
      apply(therm(300), 2'b00, "R2 stream");

      // R7 formats around the MSB boundary
      apply(therm(255), 2'b01, "R7 invert");
      apply(therm(256), 2'b01, "R7 invert");
      apply(therm(255), 2'b10, "R7 offset");
      apply(therm(256), 2'b10, "R7 offset");
      apply(therm(40),  2'b11, "R7 spare as native");
      apply(therm(0),   2'b10, "R7 offset bottom");

      // R4 bubbles
      v = therm(100); v[50] = 1'b0;
      apply(v, 2'b00, "R4 hole in run");
      v = therm(100); v[101] = 1'b1;
      apply(v, 2'b00, "R4 stray above");
      v = '0; v[5] = 1'b1;
      apply(v, 2'b00, "R4 lone stray");
      v = therm(100); v[50] = 1'b0; v[200] = 1'b1;
      apply(v, 2'b10, "R4 hole and stray");

      // R5 and R6 overflow with junk below
      v = therm(100); v[NC-1] = 1'b1;
      apply(v, 2'b00, "R6 sat native");
      apply(v, 2'b01, "R6 sat invert");
      apply(therm(512), 2'b10, "R5 full overflow");
      v = '0; v[NC-1] = 1'b1;
      apply(v, 2'b00, "R5 top only");

      // R2 random back-to-back stream
      for (int k = 0; k < 40; k++) begin
         apply(therm(int'($urandom_range(0, 511))), 2'($urandom_range(0, 3)), "R2 random");
      end
      drain();

      // R1 mid-run reset
      apply(therm(10), 2'b00, "R3 before reset");
      drain();
      @(negedge clk_i);
      #5;
      rst_i = 1'b1;
      @(posedge clk_i);
      #2;
      check("R1 mid-run reset", data_o, '0, ovf_o, 1'b0);
      @(negedge clk_i);
      #5;
      rst_i = 1'b0;
      apply(therm(77), 2'b01, "R2 after reset");
      apply(therm(78), 2'b00, "R2 after reset");
      drain();

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule